// File: doc/BRIEF.md
# Grouped Priority Interrupt Arbiter

This block chooses one interrupt to present to a processor out of many request lines. Every request line (a source) has its own fixed vector number, equal to a base value plus the source index. Sources are bundled into groups of equal size, and a group's members all take their priority from one 4-bit level register. Software programs these registers through a single-cycle write port. A level of 0 turns the whole group off.

On each clock cycle, the block finds the pending source with the highest level. When levels tie, the smallest vector number wins, and this ordering cannot be changed. A request goes to the processor only when the winning level is strictly above the processor's current mask level. The offer gives the vector number, its level and the vector-table byte offset, which is four times the vector number. The offer stays unchanged until the processor acknowledges it. The block then reports the granted vector for one cycle and sends a one-cycle clear strobe back to the winning source, but only if that source is edge-type.

The controller is a three-state machine:

- **ST_IDLE**: arbitrates on every cycle. It takes transition *offer* to ST_OFFER when a winner beats the mask, and otherwise stays.
- **ST_OFFER**: holds the captured winner and drives `irq_req`. It stays there until `irq_ack`, then takes transition *accept* to ST_GRANT.
- **ST_GRANT**: lasts one cycle. It drives `grant_valid` and the clear strobe, then takes transition *release* back to ST_IDLE.

Top module: `intc_group_arbiter`

## Requirements
- R1: After reset, every group level is 0, and `irq_req`, `grant_valid` and `src_clr` are all low. Because all levels are 0, no source can raise a request until a level is written.
- R2: Source i has vector number `VEC_BASE + i` (default base 64). `irq_offset` equals the vector number multiplied by 4.
- R3: Source i belongs to group `i / (NUM_SRC/NUM_GRP)`, which is i/2 by default. A write with `cfg_we` high sets group `cfg_addr` to the level `cfg_wdata`.
- R4: A pending source whose group level is 0 never produces a request.
- R5: A request is raised only when the winning level is strictly greater than `cpu_mask`.
- R6: Among pending enabled sources, the highest level wins, regardless of group or index.
- R7: Among pending sources of equal level, the smallest vector number wins. This holds both inside one group and across groups.
- R8: While `irq_req` is high and `irq_ack` is low, `irq_req`, `irq_vector`, `irq_level` and `irq_offset` do not change. This holds even if requests or levels change in the meantime.
- R9: The cycle after `irq_ack` is accepted:
  - `irq_req` is low.
  - `grant_valid` is high for exactly one cycle.
  - `grant_vector` carries the acknowledged vector.
- R10: In the grant cycle, `src_clr` has exactly the winner's bit set if that source is edge-type (bit set in `EDGE_MASK`, default sources 0 to 7). Otherwise `src_clr` is 0.
- R11: After a grant, the block spends one cycle idle and then arbitrates again, so a source that is still pending gets a new offer two cycles after the grant cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Level register write enable |
| cfg_addr | input | $clog2(NUM_GRP) | Group selected for the write |
| cfg_wdata | input | 4 | Level written to the group |
| src_req | input | NUM_SRC | Pending request per source |
| cpu_mask | input | 4 | Processor interrupt mask level |
| irq_ack | input | 1 | Processor acknowledge of the current offer |
| irq_req | output | 1 | Interrupt offer to the processor |
| irq_level | output | 4 | Level of the offered source |
| irq_vector | output | VEC_W | Vector number of the offered source |
| irq_offset | output | VEC_W+2 | Vector-table byte offset of the offer |
| grant_valid | output | 1 | One-cycle grant report |
| grant_vector | output | VEC_W | Vector number granted |
| src_clr | output | NUM_SRC | One-cycle clear strobe to an edge-type winner |

## Verification
The assertions check the following on every cycle:

- An offer always carries a nonzero level that is above the mask seen when it was taken.
- The offer stays frozen until it is acknowledged.
- A grant always follows an acknowledged offer, carries the offered vector, and is followed by an idle cycle.
- The clear strobe is at most one-hot and appears only during a grant.

Which source wins is shown only by the bench's scenarios:

- highest level across groups;
- lowest vector on ties, both inside a group and across groups;
- groups disabled at level 0;
- the strict mask comparison;
- whether the winner is edge-type or level-type.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int LVL_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OFFER = 2'd1,
        ST_GRANT = 2'd2
    } arb_state_t;

endpackage

// File: rtl/prio_bank.sv
module prio_bank
    import intc_pkg::*;
#(
    parameter int NUM_GRP = 8,
    parameter int GRP_AW  = $clog2(NUM_GRP)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [GRP_AW-1:0]          addr,
    input  logic [LVL_W-1:0]           wdata,
    output logic [NUM_GRP*LVL_W-1:0]   grp_lvl_flat
);

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_reg
        logic [LVL_W-1:0] lvl_q;

        // R3: one level register per group; R1: cleared by reset
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lvl_q <= '0;
            end else if (we && (addr == GRP_AW'(g))) begin
                lvl_q <= wdata;
            end
        end

        assign grp_lvl_flat[g*LVL_W +: LVL_W] = lvl_q;
    end

endmodule

// File: rtl/src_level_map.sv
module src_level_map
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int NUM_GRP = 8
) (
    input  logic [NUM_GRP*LVL_W-1:0] grp_lvl_flat,
    input  logic [NUM_SRC-1:0]       src_req,
    output logic [NUM_SRC*LVL_W-1:0] src_lvl_flat
);

    localparam int PER_GRP = NUM_SRC / NUM_GRP;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        localparam int GRP = i / PER_GRP;
        // A source that is not pending, or whose group is at level 0,
        // contributes level 0 (R4).
        assign src_lvl_flat[i*LVL_W +: LVL_W] =
            src_req[i] ? grp_lvl_flat[GRP*LVL_W +: LVL_W] : '0;
    end

endmodule

// File: rtl/win_select.sv
module win_select
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC*LVL_W-1:0] src_lvl_flat,
    output logic                     win_valid,
    output logic [IDX_W-1:0]         win_idx,
    output logic [LVL_W-1:0]         win_lvl
);

    // Scan from the top index down and accept on >=, so that on equal
    // levels the lowest index (lowest vector) is the last one taken (R7).
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_lvl   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if ((src_lvl_flat[i*LVL_W +: LVL_W] != '0) &&
                (src_lvl_flat[i*LVL_W +: LVL_W] >= win_lvl)) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
                win_lvl   = src_lvl_flat[i*LVL_W +: LVL_W];
            end
        end
    end

endmodule

// File: rtl/intc_group_arbiter.sv
module intc_group_arbiter
    import intc_pkg::*;
#(
    parameter int                 NUM_SRC   = 16,
    parameter int                 NUM_GRP   = 8,
    parameter int                 VEC_W     = 8,
    parameter int                 VEC_BASE  = 64,
    parameter logic [NUM_SRC-1:0] EDGE_MASK = 16'h00FF
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [$clog2(NUM_GRP)-1:0] cfg_addr,
    input  logic [3:0]                 cfg_wdata,
    input  logic [NUM_SRC-1:0]         src_req,
    input  logic [3:0]                 cpu_mask,
    input  logic                       irq_ack,
    output logic                       irq_req,
    output logic [3:0]                 irq_level,
    output logic [VEC_W-1:0]           irq_vector,
    output logic [VEC_W+1:0]           irq_offset,
    output logic                       grant_valid,
    output logic [VEC_W-1:0]           grant_vector,
    output logic [NUM_SRC-1:0]         src_clr
);

    localparam int IDX_W  = $clog2(NUM_SRC);
    localparam int GRP_AW = $clog2(NUM_GRP);

    logic [NUM_GRP*LVL_W-1:0] grp_lvl_flat;
    logic [NUM_SRC*LVL_W-1:0] src_lvl_flat;
    logic                     win_valid;
    logic [IDX_W-1:0]         win_idx;
    logic [LVL_W-1:0]         win_lvl;
    logic                     win_go;

    arb_state_t               state_q, state_d;
    logic [IDX_W-1:0]         held_idx_q;
    logic [LVL_W-1:0]         held_lvl_q;
    logic [VEC_W-1:0]         held_vec_q;

    prio_bank #(
        .NUM_GRP (NUM_GRP),
        .GRP_AW  (GRP_AW)
    ) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .we           (cfg_we),
        .addr         (cfg_addr),
        .wdata        (cfg_wdata),
        .grp_lvl_flat (grp_lvl_flat)
    );

    src_level_map #(
        .NUM_SRC (NUM_SRC),
        .NUM_GRP (NUM_GRP)
    ) u_map (
        .grp_lvl_flat (grp_lvl_flat),
        .src_req      (src_req),
        .src_lvl_flat (src_lvl_flat)
    );

    win_select #(
        .NUM_SRC (NUM_SRC),
        .IDX_W   (IDX_W)
    ) u_sel (
        .src_lvl_flat (src_lvl_flat),
        .win_valid    (win_valid),
        .win_idx      (win_idx),
        .win_lvl      (win_lvl)
    );

    // R5: strict comparison against the processor mask
    assign win_go = win_valid && (win_lvl > cpu_mask);

    // Next-state logic: offer / accept / release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (win_go)  state_d = ST_OFFER;
            ST_OFFER: if (irq_ack) state_d = ST_GRANT;
            ST_GRANT:              state_d = ST_IDLE;
            default:               state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Winner capture: only on the offer transition, so the offer is frozen (R8)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_idx_q <= '0;
            held_lvl_q <= '0;
            held_vec_q <= '0;
        end else if ((state_q == ST_IDLE) && win_go) begin
            held_idx_q <= win_idx;
            held_lvl_q <= win_lvl;
            held_vec_q <= VEC_W'(VEC_BASE) + VEC_W'(win_idx);
        end
    end

    // Outputs decoded from the state register
    always_comb begin
        irq_req      = 1'b0;
        grant_valid  = 1'b0;
        src_clr      = '0;
        irq_level    = held_lvl_q;
        irq_vector   = held_vec_q;
        irq_offset   = {held_vec_q, 2'b00};
        grant_vector = held_vec_q;
        unique case (state_q)
            ST_IDLE: ;
            ST_OFFER: irq_req = 1'b1;
            ST_GRANT: begin
                grant_valid = 1'b1;
                src_clr     = (NUM_SRC'(1) << held_idx_q) & EDGE_MASK;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/intc_group_arbiter_chk.sv
module intc_group_arbiter_chk #(
    parameter int NUM_SRC = 16,
    parameter int VEC_W   = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [3:0]         cpu_mask,
    input logic               irq_ack,
    input logic               irq_req,
    input logic [3:0]         irq_level,
    input logic [VEC_W-1:0]   irq_vector,
    input logic               grant_valid,
    input logic [VEC_W-1:0]   grant_vector,
    input logic [NUM_SRC-1:0] src_clr
);

    a_r4_level_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_level != 4'd0));

    a_r5_above_mask: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> (irq_level > $past(cpu_mask)));

    a_r8_offer_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_ack) |=> (irq_req && $stable(irq_vector) && $stable(irq_level)));

    a_r9_grant_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_valid) |-> ($past(irq_req) && $past(irq_ack) && !irq_req));

    a_r9_grant_vector: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_valid) |-> (grant_vector == $past(irq_vector)));

    a_r10_clr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_clr));

    a_r10_clr_in_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (src_clr != '0) |-> grant_valid);

    a_r11_idle_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |=> (!irq_req && !grant_valid));

endmodule

bind intc_group_arbiter intc_group_arbiter_chk #(
    .NUM_SRC (NUM_SRC),
    .VEC_W   (VEC_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_mask     (cpu_mask),
    .irq_ack      (irq_ack),
    .irq_req      (irq_req),
    .irq_level    (irq_level),
    .irq_vector   (irq_vector),
    .grant_valid  (grant_valid),
    .grant_vector (grant_vector),
    .src_clr      (src_clr)
);

// File: tb/test_intc_group_arbiter.sv
module test_intc_group_arbiter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [3:0]  cfg_wdata = '0;
    logic [15:0] src_req = '0;
    logic [3:0]  cpu_mask = '0;
    logic        irq_ack = 1'b0;
    logic        irq_req;
    logic [3:0]  irq_level;
    logic [7:0]  irq_vector;
    logic [9:0]  irq_offset;
    logic        grant_valid;
    logic [7:0]  grant_vector;
    logic [15:0] src_clr;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    intc_group_arbiter i_intc_group_arbiter (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_addr     (cfg_addr),
        .cfg_wdata    (cfg_wdata),
        .src_req      (src_req),
        .cpu_mask     (cpu_mask),
        .irq_ack      (irq_ack),
        .irq_req      (irq_req),
        .irq_level    (irq_level),
        .irq_vector   (irq_vector),
        .irq_offset   (irq_offset),
        .grant_valid  (grant_valid),
        .grant_vector (grant_vector),
        .src_clr      (src_clr)
    );

    // Table entry: {src_req[15:0], cpu_mask[3:0], expect_req, expect_vector[7:0]}
    // Group levels: g0=3 g1=5 g2=5 g3=0 g4=9 g5=1 g6=9 g7=2; source i in group i/2.
    localparam int NV = 10;
    localparam logic [28:0] TAB [NV] = '{
        {16'h000C, 4'd0, 1'b1, 8'd66},  // R7 tie inside group 1
        {16'h0018, 4'd0, 1'b1, 8'd67},  // R7 tie across groups 1 and 2
        {16'h0101, 4'd0, 1'b1, 8'd72},  // R6 level 9 over level 3
        {16'h0040, 4'd0, 1'b0, 8'd0},   // R4 group 3 at level 0
        {16'h0100, 4'd9, 1'b0, 8'd0},   // R5 level equal to mask
        {16'h0100, 4'd8, 1'b1, 8'd72},  // R5 level above mask
        {16'h0400, 4'd0, 1'b1, 8'd74},  // R6 single level-1 source
        {16'h4400, 4'd0, 1'b1, 8'd78},  // R6 level 2 over level 1
        {16'h1200, 4'd0, 1'b1, 8'd73},  // R7 equal level 9 across groups
        {16'h0042, 4'd2, 1'b1, 8'd65}   // R4 R5 disabled group ignored
    };

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic wr(input int g, input int lvl);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = 3'(g);
        cfg_wdata = 4'(lvl);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic ack_once();
        irq_ack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got 0 expected 1 (run finished)");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 irq_req at reset", int'(irq_req), 0);
        chk("R1 grant_valid at reset", int'(grant_valid), 0);
        chk("R1 src_clr at reset", int'(src_clr), 0);
        rst_n = 1'b1;

        // R1: all levels zero after reset, so full pending gives no offer
        @(negedge clk);
        src_req = 16'hFFFF;
        repeat (3) @(negedge clk);
        chk("R1 R4 no offer with reset levels", int'(irq_req), 0);
        src_req = '0;

        // R3: program group levels
        wr(0, 3); wr(1, 5); wr(2, 5); wr(3, 0);
        wr(4, 9); wr(5, 1); wr(6, 9); wr(7, 2);

        for (int k = 0; k < NV; k++) begin
            int          ev;
            int          idx;
            logic [15:0] eclr;
            @(negedge clk);
            src_req  = TAB[k][28:13];
            cpu_mask = TAB[k][12:9];
            ev       = int'(TAB[k][7:0]);
            idx      = ev - 64;
            @(posedge clk);
            @(negedge clk);
            chk($sformatf("R5 R6 R7 entry %0d irq_req", k), int'(irq_req), int'(TAB[k][8]));
            if (TAB[k][8]) begin
                chk($sformatf("R2 R6 R7 entry %0d vector", k), int'(irq_vector), ev);
                chk($sformatf("R2 entry %0d offset", k), int'(irq_offset), ev * 4);
                ack_once();
                eclr = (idx < 8) ? (16'h1 << idx) : 16'h0;
                chk($sformatf("R9 entry %0d grant_valid", k), int'(grant_valid), 1);
                chk($sformatf("R9 entry %0d grant_vector", k), int'(grant_vector), ev);
                chk($sformatf("R10 entry %0d src_clr", k), int'(src_clr), int'(eclr));
                chk($sformatf("R9 entry %0d irq_req dropped", k), int'(irq_req), 0);
            end
            src_req  = '0;
            cpu_mask = '0;
            repeat (2) @(negedge clk);
        end

        // R8: offer frozen while waiting for acknowledge
        @(negedge clk);
        src_req = 16'h0100;
        @(posedge clk);
        @(negedge clk);
        chk("R8 offer taken vector", int'(irq_vector), 72);
        chk("R8 offer taken level", int'(irq_level), 9);
        wr(0, 15);
        src_req = 16'h0101;
        repeat (3) @(negedge clk);
        chk("R8 irq_req held", int'(irq_req), 1);
        chk("R8 vector held", int'(irq_vector), 72);
        chk("R8 level held", int'(irq_level), 9);
        chk("R8 offset held", int'(irq_offset), 288);
        ack_once();
        chk("R9 grant of held offer", int'(grant_vector), 72);
        chk("R10 level-type source gets no strobe", int'(src_clr), 0);

        // R11: one idle cycle, then re-arbitration picks the new level-15 source
        @(negedge clk);
        chk("R11 idle cycle after grant", int'(irq_req), 0);
        chk("R11 grant_valid single cycle", int'(grant_valid), 0);
        @(negedge clk);
        chk("R11 re-offer after idle", int'(irq_req), 1);
        chk("R3 R6 new level-15 winner", int'(irq_vector), 64);
        chk("R3 new winner level", int'(irq_level), 15);
        ack_once();
        chk("R10 edge-type strobe bit 0", int'(src_clr), 1);
        src_req = '0;
        repeat (2) @(negedge clk);
        chk("R11 no offer when nothing pending", int'(irq_req), 0);

        // R5: mask at 15 blocks even level 15
        src_req  = 16'h0001;
        cpu_mask = 4'd15;
        repeat (3) @(negedge clk);
        chk("R5 mask 15 blocks level 15", int'(irq_req), 0);
        src_req  = '0;
        cpu_mask = '0;
        @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule